// File: doc/BRIEF.md
# Capture/Compare Timer Channel Array

The block runs a 16-bit counter that advances by one on every clock and wraps. Around it sits a bank of channels. Three channels only capture: each watches an external input, cleans it through a synchronizer and a pulse qualifier, and on a chosen edge stores the counter value in its own 16-bit register. Four channels only compare: each holds a 16-bit match value and compares it with the counter. When they are equal, the channel sets a flag and changes its output pin. A shared channel works as a fourth capture or as a fifth compare, depending on a mode bit. It uses the same register in both modes.

The first compare channel is the master. When it matches, it can force any subset of the compare pins, the shared pin included, to preset levels, and this override beats a pin's own match in the same cycle. Every channel event raises a sticky flag. The flag vector goes out as interrupt sources. Software configures and observes the block through a small synchronous write / combinational read register bus.

Top module: `tmr_array`

## Requirements
- R1: The counter reads 0 during reset, increases by exactly one per clock after reset, and wraps from 0xFFFF to 0x0000.
- R2: A capture input held at a new level for one clock only is ignored. A level held for two or more clocks is taken as a valid transition.
- R3: Each capture channel has a 2-bit edge select in the edge register (address 9, bits [2i+1:2i] for channel i, channel 3 being the shared one): 0 off, 1 rising, 2 falling, 3 both. A selected transition applied to the pin stores the counter value from three clocks after the pin changed, and sets status bit i.
- R4: Bus writes to a capture channel's register (addresses 1..3, and address 4 while the shared channel captures) leave the stored value unchanged.
- R5: Compare pin j (0..3) uses the register at address 5+j. Its 2-bit action sits at bits [2j+1:2j] of the action register (address 10): 0 none, 1 toggle, 2 drive low, 3 drive high. In the clock where the counter equals the register, the pin keeps its old level. From the next clock the pin shows the action's result and status bit 4+j is set.
- R6: The override register (address 11) holds a pin mask in bits [4:0] and pin levels in bits [12:8], with the shared pin at index 4. On a master match (compare pin 0), every masked pin takes its level bit, whatever its own channel does in the same clock.
- R7: The mode register (address 12, bit 0) selects the shared channel: 0 capture, with the shared output enable low and the shared pin held; 1 compare, with the enable high, the register at address 4 as a writable match value, action at bits [9:8], and status bit 3 on a match.
- R8: The status register (address 13) clears the bits written as 1. An event in the same clock as its clear leaves the bit set. The interrupt source outputs always equal the status bits.
- R9: Register reads are combinational: address 0 gives the counter, and addresses 1..8 give the channel registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_in | input | 3 | Dedicated capture inputs |
| shr_in | input | 1 | Shared channel input (capture mode) |
| cmp_out | output | 4 | Dedicated compare pins, index 0 is the master |
| shr_out | output | 1 | Shared channel output level (compare mode) |
| shr_oe | output | 1 | Shared pin output enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_src | output | 8 | Per-channel event flags toward the interrupt arbiter |

## Verification
The assertions assume that the capture inputs sit low when reset is released, because the qualified level starts at 0. They also assume that software changes a channel's mode only when no event is pending for it. The bench drives every input and bus field half a period away from the active edge and starts all pins low. It switches the shared channel to compare only after the capture tests are finished. It holds each random capture level for at least four clocks, so that each transition is judged on its own.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {EDG_OFF, EDG_RISE, EDG_FALL, EDG_BOTH} edge_sel_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_TOGGLE, ACT_LOW, ACT_HIGH} pin_act_e;

  // Qualified level just changed to new_lvl: is this edge selected?
  function automatic logic edge_taken(input logic [1:0] sel, input logic new_lvl);
    case (edge_sel_e'(sel))
      EDG_RISE: return new_lvl;
      EDG_FALL: return !new_lvl;
      EDG_BOTH: return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic act_result(input logic [1:0] act, input logic cur);
    case (pin_act_e'(act))
      ACT_TOGGLE: return !cur;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return cur;
    endcase
  endfunction

  // Master override has priority over the pin's own match.
  function automatic logic pin_next(input logic cur, input logic own_hit, input logic [1:0] act,
                                    input logic mst_hit, input logic msk, input logic lvl);
    if (mst_hit && msk) return lvl;
    if (own_hit) return act_result(act, cur);
    return cur;
  endfunction
endpackage

// File: rtl/tmr_capq.sv
module tmr_capq
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] sel,
  output logic       evt
);
  logic s1, s2, s3, qlvl;
  logic stable, changed;

  assign stable  = (s2 == s3);
  assign changed = stable && (s2 != qlvl);
  assign evt     = changed && edge_taken(sel, s2);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; qlvl <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
      if (stable) qlvl <= s2;
    end
  end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       own_hit,
  input  logic [1:0] act,
  input  logic       mst_hit,
  input  logic       msk,
  input  logic       lvl,
  output logic       pin
);
  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else if (en) pin <= pin_next(pin, own_hit, act, mst_hit, msk, lvl);
  end
endmodule

// File: rtl/tmr_array.sv
module tmr_array
  import tmr_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NCAP = 3,
  parameter int NCMP = 4,
  parameter int AW   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCAP-1:0]      cap_in,
  input  logic                 shr_in,
  output logic [NCMP-1:0]      cmp_out,
  output logic                 shr_out,
  output logic                 shr_oe,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [CW-1:0]        bus_wdata,
  output logic [CW-1:0]        bus_rdata,
  output logic [NCAP+NCMP:0]   irq_src
);
  localparam int NCH    = NCAP + 1 + NCMP;
  localparam int NPIN   = NCMP + 1;
  localparam int A_ESEL = NCH + 1;
  localparam int A_ACT  = NCH + 2;
  localparam int A_OVR  = NCH + 3;
  localparam int A_MODE = NCH + 4;
  localparam int A_STAT = NCH + 5;
  localparam int OVR_LVL_LSB = 8;

  logic [CW-1:0]            cnt;
  logic [NCH-1:0][CW-1:0]   chr;
  logic [2*(NCAP+1)-1:0]    esel;
  logic [2*NPIN-1:0]        actr;
  logic [NPIN-1:0]          mmask, mdata, pin_en, pin_q, cmp_hit;
  logic                     shr_cmp;
  logic [NCH-1:0]           flags, ev, clr;
  logic [NCAP:0]            cap_evt;

  // free-running counter
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // capture qualifiers: dedicated inputs, then the shared one
  for (genvar i = 0; i <= NCAP; i++) begin : g_cap
    logic raw_evt;
    if (i < NCAP) begin : g_ded
      tmr_capq u_q (.clk(clk), .rst(rst), .pin(cap_in[i]), .sel(esel[2*i+:2]), .evt(raw_evt));
      assign cap_evt[i] = raw_evt;
    end else begin : g_shr
      tmr_capq u_q (.clk(clk), .rst(rst), .pin(shr_in), .sel(esel[2*i+:2]), .evt(raw_evt));
      assign cap_evt[i] = raw_evt && !shr_cmp;
    end
  end

  // comparators and output pins (index NCMP is the shared pin)
  for (genvar j = 0; j < NPIN; j++) begin : g_cmp
    if (j < NCMP) begin : g_ded
      assign cmp_hit[j] = (cnt == chr[NCAP+1+j]);
      assign pin_en[j]  = 1'b1;
      assign ev[NCAP+1+j] = cmp_hit[j];
    end else begin : g_shr
      assign cmp_hit[j] = shr_cmp && (cnt == chr[NCAP]);
      assign pin_en[j]  = shr_cmp;
    end
    tmr_pin u_pin (
      .clk(clk), .rst(rst), .en(pin_en[j]), .own_hit(cmp_hit[j]), .act(actr[2*j+:2]),
      .mst_hit(cmp_hit[0]), .msk(mmask[j]), .lvl(mdata[j]), .pin(pin_q[j])
    );
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_capev
    assign ev[i] = cap_evt[i];
  end
  assign ev[NCAP] = shr_cmp ? cmp_hit[NCMP] : cap_evt[NCAP];

  function automatic logic wr_at(input int a);
    return bus_we && (bus_addr == AW'(a));
  endfunction

  assign clr = wr_at(A_STAT) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      chr <= '0; esel <= '0; actr <= '0; mmask <= '0; mdata <= '0;
      shr_cmp <= 1'b0; flags <= '0;
    end else begin
      for (int i = 0; i < NCAP; i++)
        if (cap_evt[i]) chr[i] <= cnt;
      if (cap_evt[NCAP]) chr[NCAP] <= cnt;
      else if (shr_cmp && wr_at(NCAP + 1)) chr[NCAP] <= bus_wdata;
      for (int i = NCAP + 1; i < NCH; i++)
        if (wr_at(i + 1)) chr[i] <= bus_wdata;
      if (wr_at(A_ESEL)) esel <= bus_wdata[2*(NCAP+1)-1:0];
      if (wr_at(A_ACT))  actr <= bus_wdata[2*NPIN-1:0];
      if (wr_at(A_OVR)) begin
        mmask <= bus_wdata[NPIN-1:0];
        mdata <= bus_wdata[OVR_LVL_LSB+:NPIN];
      end
      if (wr_at(A_MODE)) shr_cmp <= bus_wdata[0];
      flags <= (flags & ~clr) | ev;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0)) bus_rdata = cnt;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(i + 1)) bus_rdata = chr[i];
    if (bus_addr == AW'(A_ESEL)) bus_rdata = CW'(esel);
    if (bus_addr == AW'(A_ACT))  bus_rdata = CW'(actr);
    if (bus_addr == AW'(A_OVR)) begin
      bus_rdata[NPIN-1:0] = mmask;
      bus_rdata[OVR_LVL_LSB+:NPIN] = mdata;
    end
    if (bus_addr == AW'(A_MODE)) bus_rdata = CW'(shr_cmp);
    if (bus_addr == AW'(A_STAT)) bus_rdata = CW'(flags);
  end

  assign cmp_out = pin_q[NCMP-1:0];
  assign shr_out = pin_q[NCMP];
  assign shr_oe  = shr_cmp;
  assign irq_src = flags;
endmodule

// File: rtl/tmr_array_chk.sv
module tmr_array_chk #(
  parameter int CW   = 16,
  parameter int NCAP = 3,
  parameter int NCMP = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [CW-1:0]                 cnt,
  input logic [NCAP+NCMP:0][CW-1:0]    chr,
  input logic [NCAP:0]                 cap_evt,
  input logic [NCAP+NCMP:0]            ev,
  input logic [NCAP+NCMP:0]            flags,
  input logic                          mst_hit,
  input logic [NCMP:0]                 mmask,
  input logic [NCMP:0]                 mdata,
  input logic [NCMP:0]                 pin_en,
  input logic [NCMP:0]                 pins,
  input logic                          shr_cmp
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt == CW'($past(cnt) + 1'b1));

  for (genvar i = 0; i <= NCAP; i++) begin : g_cap
    a_r3_capture_value: assert property (@(posedge clk) disable iff (rst)
      cap_evt[i] |=> chr[i] == $past(cnt));
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_hold
    a_r4_capture_hold: assert property (@(posedge clk) disable iff (rst)
      !cap_evt[i] |=> chr[i] == $past(chr[i]));
  end

  for (genvar i = 0; i <= NCAP + NCMP; i++) begin : g_flag
    a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> flags[i]);
  end

  for (genvar j = 0; j <= NCMP; j++) begin : g_ovr
    a_r6_master_override: assert property (@(posedge clk) disable iff (rst)
      (mst_hit && mmask[j] && pin_en[j]) |=> pins[j] == $past(mdata[j]));
  end

  a_r7_shared_pin_held: assert property (@(posedge clk) disable iff (rst)
    !shr_cmp |=> pins[NCMP] == $past(pins[NCMP]));
endmodule

bind tmr_array tmr_array_chk #(.CW(CW), .NCAP(NCAP), .NCMP(NCMP)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .chr(chr), .cap_evt(cap_evt), .ev(ev), .flags(flags),
  .mst_hit(cmp_hit[0]), .mmask(mmask), .mdata(mdata), .pin_en(pin_en), .pins(pin_q),
  .shr_cmp(shr_cmp)
);

// File: tb/sim_tmr_array.sv
`timescale 1ns/1ps
module sim_tmr_array;
  localparam logic [3:0] A_CNT = 4'd0, A_ESEL = 4'd9, A_ACT = 4'd10, A_OVR = 4'd11,
                         A_MODE = 4'd12, A_STAT = 4'd13;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] cap_in = '0;
  logic shr_in = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [3:0] cmp_out;
  logic shr_out, shr_oe;
  logic [15:0] bus_rdata;
  logic [7:0] irq_src;

  int checks = 0, errors = 0;
  logic [15:0] capv [4];
  logic lvl [4];
  logic pinv [4];

  always #4 clk = ~clk;

  tmr_array u0 (.clk(clk), .rst(rst), .cap_in(cap_in), .shr_in(shr_in), .cmp_out(cmp_out),
    .shr_out(shr_out), .shr_oe(shr_oe), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src));

  function automatic logic exp_edge(input int sel, input logic nl);
    return (sel == 3) || (sel == 1 && nl) || (sel == 2 && !nl);
  endfunction

  function automatic logic exp_pin(input int act, input logic cur);
    if (act == 1) return !cur;
    if (act == 2) return 1'b0;
    if (act == 3) return 1'b1;
    return cur;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic drive_cap(input int ch, input logic v);
    if (ch < 3) cap_in[ch] = v; else shr_in = v;
  endtask

  // waits at negedges until the counter reads v
  task automatic wait_cnt(input logic [15:0] v);
    logic [15:0] d;
    for (int k = 0; k < 80; k++) begin
      rd(A_CNT, d);
      if (d == v) return;
      @(negedge clk);
    end
    chk("R5 counter reached target", d, v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, c0, v;
    void'($urandom(32'h1357));
    for (int i = 0; i < 4; i++) begin capv[i] = '0; lvl[i] = 1'b0; pinv[i] = 1'b0; end

    repeat (3) @(negedge clk);
    rd(A_CNT, d);  chk("R1 counter in reset", d, 16'h0);
    rd(A_STAT, d); chk("R8 status in reset", d, 16'h0);
    chk("R5 pins in reset", {cmp_out, shr_out}, 5'h0);
    chk("R7 shared enable in reset", shr_oe, 1'b0);
    rst = 1'b0;

    // R1 step and wrap
    @(negedge clk); rd(A_CNT, c0);
    repeat (5) @(negedge clk);
    rd(A_CNT, d); chk("R1 step by one", d, 16'(c0 + 5));
    wait_wrap: for (int k = 0; k < 70000; k++) begin
      rd(A_CNT, d);
      if (d == 16'hFFFF) break;
      @(negedge clk);
    end
    @(negedge clk); rd(A_CNT, d); chk("R1 wrap to zero", d, 16'h0);

    // R2: one-clock pulse ignored, three-clock pulse taken (channel 0, rising)
    wr(A_ESEL, 16'h0001);
    wr(A_STAT, 16'hFFFF);
    cap_in[0] = 1'b1; @(negedge clk); cap_in[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(A_STAT, d); chk("R2 one-clock pulse ignored", d[0], 1'b0);
    rd(4'd1, d);   chk("R2 register kept after glitch", d, capv[0]);
    rd(A_CNT, c0); cap_in[0] = 1'b1;
    repeat (3) @(negedge clk); cap_in[0] = 1'b0;
    @(negedge clk);
    capv[0] = 16'(c0 + 3);
    rd(A_STAT, d); chk("R2 long pulse taken", d[0], 1'b1);
    rd(4'd1, d);   chk("R3 rising capture value", d, capv[0]);
    repeat (6) @(negedge clk);
    rd(4'd1, d);   chk("R3 falling edge not selected", d, capv[0]);

    // R4: bus write to capture register ignored
    wr(4'd1, 16'hBEEF);
    rd(4'd1, d); chk("R4 capture register write ignored", d, capv[0]);

    // R3 falling only on channel 1
    wr(A_ESEL, 16'h0008);
    wr(A_STAT, 16'hFFFF);
    cap_in[1] = 1'b1; repeat (5) @(negedge clk);
    rd(A_STAT, d); chk("R3 rise with falling select", d[1], 1'b0);
    rd(A_CNT, c0); cap_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    capv[1] = 16'(c0 + 3);
    rd(A_STAT, d); chk("R3 fall sets flag", d[1], 1'b1);
    rd(4'd2, d);   chk("R3 fall capture value", d, capv[1]);

    // random captures over channels 0..3 (shared in capture mode)
    for (int it = 0; it < 24; it++) begin
      int ch, sel;
      logic nl, hit;
      ch = $urandom_range(0, 3); sel = $urandom_range(0, 3);
      wr(A_ESEL, 16'(sel << (2 * ch)));
      wr(A_STAT, 16'hFFFF);
      nl = !lvl[ch];
      drive_cap(ch, nl);
      rd(A_CNT, c0);
      repeat (4) @(negedge clk);
      hit = exp_edge(sel, nl);
      if (hit) capv[ch] = 16'(c0 + 3);
      lvl[ch] = nl;
      rd(A_STAT, d); chk("R3 random edge flag", d[ch], hit);
      rd(4'(ch + 1), d); chk("R3 random capture value", d, capv[ch]);
    end
    chk("R7 shared pin not driven in capture mode", shr_oe, 1'b0);

    // R5 directed and random compare actions
    for (int it = 0; it < 14; it++) begin
      int j, act;
      j = (it == 0) ? 1 : $urandom_range(1, 3);
      act = (it == 0) ? 3 : $urandom_range(0, 3);
      wr(A_ACT, 16'(act << (2 * j)));
      wr(A_STAT, 16'hFFFF);
      rd(A_CNT, c0); v = 16'(c0 + 12);
      wr(4'(5 + j), v);
      wait_cnt(v);
      chk("R5 pin unchanged in match clock", cmp_out[j], pinv[j]);
      @(negedge clk);
      pinv[j] = exp_pin(act, pinv[j]);
      chk("R5 pin after match", cmp_out[j], pinv[j]);
      rd(A_STAT, d); chk("R5 compare flag", d[4 + j], 1'b1);
      chk("R8 irq equals status", irq_src, d[7:0]);
    end

    // R6 master override beats own action
    wr(A_OVR, 16'h0406);          // mask pins 1,2; level pin1=0, pin2=1
    wr(A_ACT, 16'h000D);          // pin0 toggle, pin1 drive high
    rd(A_CNT, c0); v = 16'(c0 + 14);
    wr(4'd5, v); wr(4'd6, v);
    wait_cnt(v);
    @(negedge clk);
    pinv[0] = !pinv[0];
    chk("R6 master own toggle", cmp_out[0], pinv[0]);
    chk("R6 override beats own action", cmp_out[1], 1'b0);
    chk("R6 override drives masked pin", cmp_out[2], 1'b1);
    chk("R6 unmasked pin untouched", cmp_out[3], pinv[3]);
    pinv[1] = 1'b0; pinv[2] = 1'b1;
    wr(A_OVR, 16'h0000);

    // R7 shared compare, R8 set beats clear
    wr(A_MODE, 16'h0001);
    chk("R7 shared enable in compare mode", shr_oe, 1'b1);
    wr(A_ACT, 16'h0300);
    wr(A_STAT, 16'hFFFF);
    rd(A_CNT, c0); v = 16'(c0 + 12);
    wr(4'd4, v);
    rd(4'd4, d); chk("R9 shared register readback", d, v);
    wait_cnt(v);
    bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = 16'h0008;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R7 shared pin driven on match", shr_out, 1'b1);
    rd(A_STAT, d); chk("R8 event beats same-clock clear", d[3], 1'b1);
    chk("R8 irq shows shared flag", irq_src[3], 1'b1);
    wr(A_STAT, 16'h0008);
    rd(A_STAT, d); chk("R8 write-one clears", d[3], 1'b0);
    chk("R8 irq follows clear", irq_src[3], 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule